// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers up to eight interrupt sources, holds them in a request register, and tracks the requests being serviced in an in-service register. It raises a single interrupt line to an 8-bit processor. The processor answers with a series of acknowledge pulses, and the controller returns one byte per pulse. Together those bytes form a three-byte subroutine call into a vector table. Inputs are sensed either on their rising edges or by level, chosen by a bit in the initialization word. Priority is fixed, with input 0 the highest.

Software configures and services the block through a small write port with one address bit. A write to address 0 with data bit 4 set starts initialization. The write to address 1 that follows supplies the high byte of the vector table. Later writes to address 1 set the mask, and other writes to address 0 are end-of-interrupt commands. An acknowledge moves a request from the request register into service. An end-of-interrupt command only ends service and never touches a pending request.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, `int_out` is low and `ack_data` is 0x00. All eight inputs start masked, so no request can raise `int_out` before initialization.
- R2: A write of address 0 with data bit 4 set is the init word. Bit 3 selects level sensing (1) or edge sensing (0), and bits 7:5 give vector-table address bits 7:5. The init word clears the request, in-service and mask registers. The next write to address 1 loads address bits 15:8. Later writes to address 1 load the mask, where bit i = 1 masks input i.
- R3: In edge mode, a rising edge on an input latches a request. An input held high after its request has been serviced does not request again.
- R4: In level mode, an input that is still high after its end-of-interrupt is requested again.
- R5: Priority is fixed with input 0 highest. `int_out` is high only when an unmasked pending request has higher priority than every in-service input.
- R6: One interrupt takes three `inta` pulses, which return 0xCD, then the low byte, then the high byte of the table address plus 4 × input number. The first pulse sets the winner's in-service bit and clears its request.
- R7: The non-specific end-of-interrupt (address 0, data 0x20) clears only the highest-priority in-service bit.
- R8: The specific end-of-interrupt (address 0, data 0x60 | n) clears in-service bit n only.
- R9: An end-of-interrupt never clears a pending request. A masked request stays latched and is raised once it is unmasked.
- R10: An acknowledge with no eligible request returns the call sequence for input 7 and leaves the in-service register unchanged.
- R11: `ack_data` holds its value between `inta` pulses, and the pulse after a third one starts a new sequence with 0xCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Asynchronous interrupt request lines, bit 0 highest priority |
| wr_en | input | 1 | Write strobe for one clock cycle |
| wr_addr | input | 1 | Write address (0 = init word / end-of-interrupt, 1 = high address byte / mask) |
| wr_data | input | 8 | Write data |
| inta | input | 1 | Acknowledge pulse for one clock cycle, one per byte |
| int_out | output | 1 | Interrupt request to the processor |
| ack_data | output | 8 | Byte answered to the latest acknowledge, valid from the cycle after `inta` |

## Verification
A wrong in-service bit shows up on `int_out`. A stray bit blocks lower requests that should be raised, and a lost bit lets a lower request interrupt a handler. Either fault appears in the cycle after the write or acknowledge that caused it. A wrong request bit or priority choice shows up in the low byte of the call address on the second acknowledge. Wrong sensing shows up as a missing or extra `int_out` three cycles after the input changes.

// File: rtl/pic8_pkg.sv
// Package pic8_pkg
// Shared sizes, constants and helpers for the eight-input interrupt controller.
// Assumes the input count is a power of two and that the vector slot spacing
// is a power of two.
package pic8_pkg;
    localparam int IRQ_N      = 8;
    localparam int IDX_W      = $clog2(IRQ_N);
    localparam int SLOT_SHIFT = 2;
    localparam int VEC_HI_W   = 3;
    localparam int ADDR_W     = 16;
    localparam logic [7:0] CALL_OP = 8'hCD;
    localparam logic [2:0] CMD_EOI_ANY = 3'b001;
    localparam logic [2:0] CMD_EOI_ONE = 3'b011;

    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_LO  = 2'd1,
        PH_HI  = 2'd2
    } ack_phase_e;

    // Returns the index of the lowest set bit (the highest priority); 0 if none.
    function automatic logic [IDX_W-1:0] pick_top(input logic [IRQ_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // Returns a one-hot vector with bit idx set.
    function automatic logic [IRQ_N-1:0] one_hot(input logic [IDX_W-1:0] idx);
        logic [IRQ_N-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pic8_sense.sv
// Module pic8_sense
// Synchronizes the request inputs and maintains the request register.
// Edge mode latches on a rising edge of the synchronized input. Level mode
// follows the synchronized level. Assumes inputs are asynchronous, and that
// ack_clr and init_clr are single-cycle pulses.
module pic8_sense
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] irq_in,
    input  logic             level_mode,
    input  logic             init_clr,
    input  logic [IRQ_N-1:0] ack_clr,
    output logic [IRQ_N-1:0] irr
);
    for (genvar g = 0; g < IRQ_N; g++) begin : g_line
        logic s1, s2, prev;
        logic rise;

        // Two-stage synchronizer plus previous-sample stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= irq_in[g];
                s2   <= s1;
                prev <= s2;
            end
        end

        assign rise = s2 & ~prev;

        // Request bit: level follows the line, edge is sticky until acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n || init_clr) begin
                irr[g] <= 1'b0;
            end else if (level_mode) begin
                irr[g] <= s2 & ~ack_clr[g];
            end else begin
                irr[g] <= (irr[g] & ~ack_clr[g]) | rise;
            end
        end
    end
endmodule

// File: rtl/pic8_cmd.sv
// Module pic8_cmd
// Decodes the write port: the init word, the high address byte, the mask and
// the end-of-interrupt commands. It holds the configuration registers.
// Assumes wr_en lasts one cycle per write.
module pic8_cmd
    import pic8_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [IRQ_N-1:0]    isr,
    output logic                init_pulse,
    output logic                level_mode,
    output logic [VEC_HI_W-1:0] vec_hi,
    output logic [7:0]          base_hi,
    output logic [IRQ_N-1:0]    imr,
    output logic [IRQ_N-1:0]    eoi_clr
);
    logic expect_hi;
    logic wr_cmd;
    logic wr_ctl;

    assign wr_cmd     = wr_en && !wr_addr;
    assign wr_ctl     = wr_en && wr_addr;
    assign init_pulse = wr_cmd && wr_data[4];

    // Configuration registers and the address-1 byte sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode <= 1'b0;
            vec_hi     <= '0;
            base_hi    <= '0;
            imr        <= '1;
            expect_hi  <= 1'b0;
        end else if (init_pulse) begin
            level_mode <= wr_data[3];
            vec_hi     <= wr_data[7:8-VEC_HI_W];
            imr        <= '0;
            expect_hi  <= 1'b1;
        end else if (wr_ctl) begin
            if (expect_hi) begin
                base_hi   <= wr_data;
                expect_hi <= 1'b0;
            end else begin
                imr <= wr_data[IRQ_N-1:0];
            end
        end
    end

    // End-of-interrupt decode into a clear mask for the in-service register.
    always_comb begin
        eoi_clr = '0;
        if (wr_cmd && !wr_data[4]) begin
            if (wr_data[7:5] == CMD_EOI_ANY && |isr) begin
                eoi_clr = one_hot(pick_top(isr));
            end else if (wr_data[7:5] == CMD_EOI_ONE) begin
                eoi_clr = one_hot(wr_data[IDX_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/pic8_prio.sv
// Module pic8_prio
// Fixed-priority resolver with input 0 highest. It selects the best unmasked
// request and raises int_req only when that request beats every in-service
// input. Purely combinational.
module pic8_prio
    import pic8_pkg::*;
(
    input  logic [IRQ_N-1:0] irr,
    input  logic [IRQ_N-1:0] imr,
    input  logic [IRQ_N-1:0] isr,
    output logic             int_req,
    output logic [IDX_W-1:0] win_idx
);
    logic [IRQ_N-1:0] pend;
    logic [IDX_W-1:0] isr_top;

    // Compare the best pending request against the best in-service input.
    always_comb begin
        pend    = irr & ~imr;
        win_idx = pick_top(pend);
        isr_top = pick_top(isr);
        int_req = (|pend) && ((isr == '0) || (win_idx < isr_top));
    end
endmodule

// File: rtl/pic8_ack.sv
// Module pic8_ack
// Acknowledge sequencer. It answers three inta pulses with the call opcode and
// then the two bytes of the vector address. On the first pulse it moves the
// winner into service. Assumes inta lasts one cycle per byte.
module pic8_ack
    import pic8_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inta,
    input  logic                init_pulse,
    input  logic                int_req,
    input  logic [IDX_W-1:0]    win_idx,
    input  logic [VEC_HI_W-1:0] vec_hi,
    input  logic [7:0]          base_hi,
    output logic [IRQ_N-1:0]    take,
    output logic [1:0]          phase_o,
    output logic [7:0]          ack_data
);
    localparam int LO_PAD = 8 - VEC_HI_W;

    ack_phase_e       phase;
    logic [IDX_W-1:0] win_q;
    logic [ADDR_W-1:0] target;

    assign phase_o = phase;
    assign target  = {base_hi, vec_hi, {LO_PAD{1'b0}}}
                   + (ADDR_W'(win_q) << SLOT_SHIFT);

    // Winner handover on the first pulse; spurious acknowledges take nothing.
    always_comb begin
        take = '0;
        if (inta && phase == PH_OPC && int_req) take = one_hot(win_idx);
    end

    // Phase counter, latched winner and the answered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OPC;
            win_q    <= '0;
            ack_data <= 8'h00;
        end else if (init_pulse) begin
            phase <= PH_OPC;
        end else if (inta) begin
            unique case (phase)
                PH_OPC: begin
                    win_q    <= int_req ? win_idx : IDX_W'(IRQ_N - 1);
                    ack_data <= CALL_OP;
                    phase    <= PH_LO;
                end
                PH_LO: begin
                    ack_data <= target[7:0];
                    phase    <= PH_HI;
                end
                default: begin
                    ack_data <= target[15:8];
                    phase    <= PH_OPC;
                end
            endcase
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
// Module pic8_ctrl
// Top of the eight-input priority interrupt controller. It wires request
// sensing, command decode, priority and the acknowledge sequencer, and holds
// the in-service register. Assumes a single clock and a synchronous
// active-low reset.
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] irq_in,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       inta,
    output logic       int_out,
    output logic [7:0] ack_data
);
    logic [IRQ_N-1:0]    irr, imr, isr, eoi_clr, take;
    logic                init_pulse, level_mode, int_req;
    logic [VEC_HI_W-1:0] vec_hi;
    logic [7:0]          base_hi;
    logic [IDX_W-1:0]    win_idx;
    logic [1:0]          ack_phase;

    pic8_sense u_sense (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
        .init_clr(init_pulse), .ack_clr(take), .irr(irr)
    );

    pic8_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .isr(isr), .init_pulse(init_pulse),
        .level_mode(level_mode), .vec_hi(vec_hi), .base_hi(base_hi),
        .imr(imr), .eoi_clr(eoi_clr)
    );

    pic8_prio u_prio (
        .irr(irr), .imr(imr), .isr(isr), .int_req(int_req), .win_idx(win_idx)
    );

    pic8_ack u_ack (
        .clk(clk), .rst_n(rst_n), .inta(inta), .init_pulse(init_pulse),
        .int_req(int_req), .win_idx(win_idx), .vec_hi(vec_hi),
        .base_hi(base_hi), .take(take), .phase_o(ack_phase),
        .ack_data(ack_data)
    );

    // In-service register: set by the first acknowledge, cleared by EOI or init.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) begin
            isr <= '0;
        end else begin
            isr <= (isr & ~eoi_clr) | take;
        end
    end

    assign int_out = int_req;
endmodule

// File: rtl/pic8_ctrl_chk.sv
// Module pic8_ctrl_chk
// Property checker for pic8_ctrl. It is attached through bind and observes
// ports and internal registers only.
module pic8_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inta,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       int_out,
    input logic [7:0] ack_data,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic [7:0] isr,
    input logic [1:0] ack_phase
);
    // R6
    first_ack_takes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ack_phase == 2'd0 && int_out && !wr_en)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R6
    opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ack_phase == 2'd0) |=> (ack_data == 8'hCD));

    // R5
    int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != 8'h00));

    // R8
    specific_eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[7:5] == 3'b011 && !wr_data[4] && !inta)
        |=> !isr[$past(wr_data[2:0])]);

    // R7
    eoi_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && !wr_data[4] && !inta)
        |=> ((isr & ~$past(isr)) == 8'h00));

    // R11
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_phase != 2'd3);

    // R11
    data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta && !wr_en) |=> $stable(ack_data));
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .int_out(int_out), .ack_data(ack_data), .irr(irr),
    .imr(imr), .isr(isr), .ack_phase(ack_phase)
);

// File: tb/pic8_ctrl_tb.sv
// Directed bench for pic8_ctrl: one task per scenario, each checking its results.
module pic8_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = 8'h00;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       inta = 1'b0;
    logic       int_out;
    logic [7:0] ack_data;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pic8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .inta(inta),
        .int_out(int_out), .ack_data(ack_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(output logic [7:0] b);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        b = ack_data;
    endtask

    task automatic ack3(input string req, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] b;
        ack(b); chk({req, " opcode"}, b, 8'hCD);
        ack(b); chk({req, " low"}, b, lo);
        ack(b); chk({req, " high"}, b, hi);
    endtask

    task automatic t_reset();
        chk("R1 int_out at reset", {7'd0, int_out}, 8'h00);
        chk("R1 ack_data at reset", ack_data, 8'h00);
        irq_in[0] = 1'b1; idle(6);
        chk("R1 masked before init", {7'd0, int_out}, 8'h00);
        irq_in[0] = 1'b0; idle(4);
    endtask

    task automatic t_edge();
        wr(1'b0, 8'hB0);
        wr(1'b1, 8'h12);
        idle(2);
        chk("R2 init clears pending", {7'd0, int_out}, 8'h00);
        irq_in[3] = 1'b1; idle(5);
        chk("R3 edge raises int", {7'd0, int_out}, 8'h01);
        ack3("R6 input3", 8'hAC, 8'h12);
        chk("R6 ack moves to service", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20); idle(6);
        chk("R3 held line not re-requested", {7'd0, int_out}, 8'h00);
        irq_in[3] = 1'b0; idle(4);
    endtask

    task automatic t_mask();
        logic [7:0] b;
        wr(1'b1, 8'h10);
        irq_in[4] = 1'b1; idle(5);
        chk("R2 mask blocks input4", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h64); idle(2);
        wr(1'b1, 8'h00); idle(1);
        chk("R9 request survives EOI and mask", {7'd0, int_out}, 8'h01);
        ack(b); chk("R11 opcode", b, 8'hCD);
        idle(3);
        chk("R11 ack_data held", ack_data, 8'hCD);
        ack(b); chk("R6 input4 low", b, 8'hB0);
        ack(b); chk("R6 input4 high", b, 8'h12);
        wr(1'b0, 8'h64);
        irq_in[4] = 1'b0; idle(4);
    endtask

    task automatic t_priority();
        irq_in[2] = 1'b1; irq_in[5] = 1'b1; idle(5);
        chk("R5 int with two requests", {7'd0, int_out}, 8'h01);
        ack3("R5 input2 wins", 8'hA8, 8'h12);
        chk("R5 lower request blocked", {7'd0, int_out}, 8'h00);
        irq_in[1] = 1'b1; idle(5);
        chk("R5 higher request nests", {7'd0, int_out}, 8'h01);
        ack3("R5 input1", 8'hA4, 8'h12);
        wr(1'b0, 8'h20); idle(1);
        chk("R7 input2 still in service", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h62); idle(1);
        chk("R8 specific EOI frees input5", {7'd0, int_out}, 8'h01);
        ack3("R8 input5", 8'hB4, 8'h12);
        wr(1'b0, 8'h65);
        irq_in = 8'h00; idle(4);
        chk("R8 all clear", {7'd0, int_out}, 8'h00);
    endtask

    task automatic t_spurious();
        ack3("R10 spurious", 8'hBC, 8'h12);
        ack3("R11 wrap", 8'hBC, 8'h12);
        irq_in[7] = 1'b1; idle(5);
        chk("R10 input7 not left in service", {7'd0, int_out}, 8'h01);
        ack3("R10 input7", 8'hBC, 8'h12);
        wr(1'b0, 8'h67);
        irq_in[7] = 1'b0; idle(4);
    endtask

    task automatic t_level();
        wr(1'b0, 8'h18);
        wr(1'b1, 8'h34);
        irq_in[6] = 1'b1; idle(5);
        chk("R4 level raises int", {7'd0, int_out}, 8'h01);
        ack3("R2 level base", 8'h18, 8'h34);
        chk("R4 in service blocks", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20); idle(1);
        chk("R4 level re-requested", {7'd0, int_out}, 8'h01);
        ack3("R4 second service", 8'h18, 8'h34);
        irq_in[6] = 1'b0; idle(4);
        wr(1'b0, 8'h20); idle(2);
        chk("R4 dropped line idle", {7'd0, int_out}, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_edge();
        t_mask();
        t_priority();
        t_spurious();
        t_level();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule